// File: doc/BRIEF.md
# Packet ID Rule Matcher

This block performs the routing lookup for one input port of a stream switch. The port keeps a small table of rules. Each rule holds a valid bit, a 5-bit mask, a 5-bit expected ID and a routing tag, which selects the arbiter and output group. When a packet header is accepted, the block takes the packet ID from the header and tests it against every slot. One cycle later it reports the tag and slot index of the lowest-numbered valid slot whose masked ID equals its stored value. If no slot matches, it raises a miss flag so the packet can be dropped.

A rule compares the packet ID against the stored value only on the bits where its mask is 1. Rules may overlap. Because the slots are scanned strictly in order, a narrow rule placed ahead of a broad one takes the IDs it names, and the broad rule handles the rest. Rules are loaded through a single-cycle write port that gives the slot index and the full rule contents. The number of slots is fixed, so no configuration can hold more rules than the port supports.

Top module: `pkt_rule_matcher`

## Requirements
- R1: After reset, every slot is invalid, `res_valid` is 0, and any header accepted before the first rule write reports a miss.
- R2: A valid slot matches when (packet ID AND slot mask) equals the slot's stored value, compared over all 5 bits. A stored value with a 1 where the mask is 0 never matches.
- R3: An ID bit is ignored where the mask bit is 0 and must equal the stored bit where the mask bit is 1. Mask 31 matches exactly one ID, and mask 30 with value 0 matches IDs 0 and 1 only.
- R4: When several valid slots match, the result reports the tag and index of the lowest-numbered one.
- R5: A slot whose valid bit is 0 never matches, whatever its mask and value hold.
- R6: A header is accepted on a cycle where `hdr_valid` and `hdr_ready` are both 1. `res_valid` is 1 in exactly the cycle after each acceptance and 0 otherwise.
- R7: On a miss, `res_miss` is 1, `res_hit` is 0, and `res_tag` and `res_slot` are both 0.
- R8: The packet ID is bits [4:0] of `hdr_data`. Bits [31:5] have no effect on the result.
- R9: A rule write with `cfg_we` = 1 replaces only the addressed slot. A header accepted in the same cycle as a write is matched against the table as it stood before that write.
- R10: `hdr_ready` is 1 whenever reset is low. While `res_valid` is 1, exactly one of `res_hit` and `res_miss` is 1, and both are 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Rule write strobe |
| cfg_slot | input | 2 | Slot index being written |
| cfg_mask | input | 5 | Mask of the written rule (1 = bit compared) |
| cfg_value | input | 5 | Expected ID of the written rule |
| cfg_tag | input | 3 | Routing tag of the written rule |
| cfg_valid | input | 1 | Valid bit of the written rule |
| hdr_valid | input | 1 | Header word present |
| hdr_ready | output | 1 | Block can accept a header |
| hdr_data | input | 32 | Header word; packet ID in bits [4:0] |
| res_valid | output | 1 | Lookup result present |
| res_hit | output | 1 | A rule matched |
| res_miss | output | 1 | No rule matched; the packet should be dropped |
| res_tag | output | 3 | Tag of the winning rule |
| res_slot | output | 2 | Index of the winning rule |

## Verification
Every one of the 32 packet IDs is swept against several tables. The first table is empty, which tells a working miss path apart from a stale or default hit. The next has narrow rules placed ahead of broader overlapping ones, and it contains an invalid slot that would match everything, so any priority inversion or ignored valid bit shows up as a wrong tag on specific IDs. A catch-all is then added in the last slot and later moved to the first slot, which shows whether ordering alone decides the winner. Upper header bits are filled with a varying pattern to expose any use of bits outside the ID field. A write issued in the same cycle as a header shows whether the lookup sees the old or the new rule.

// File: rtl/pkt_rule_pkg.sv
package pkt_rule_pkg;

    localparam int ID_W      = 5;
    localparam int NUM_SLOTS = 4;
    localparam int TAG_W     = 3;
    localparam int HDR_W     = 32;
    localparam int SLOT_W    = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1;

    typedef logic [ID_W-1:0]   pkt_id_t;
    typedef logic [TAG_W-1:0]  tag_t;
    typedef logic [SLOT_W-1:0] slot_idx_t;
    typedef logic [HDR_W-1:0]  hdr_word_t;

    typedef struct packed {
        logic    valid;
        pkt_id_t mask;
        pkt_id_t value;
        tag_t    tag;
    } rule_t;

    typedef struct packed {
        logic      hit;
        slot_idx_t slot;
        tag_t      tag;
    } lookup_t;

    // Masked-equality test of one rule against one packet ID.
    function automatic logic rule_accepts(rule_t r, pkt_id_t id);
        return r.valid && ((id & r.mask) == r.value);
    endfunction

    // Packet ID field of a header word.
    function automatic pkt_id_t header_to_id(hdr_word_t h);
        return h[ID_W-1:0];
    endfunction

endpackage

// File: rtl/pkt_rule_table.sv
module pkt_rule_table
    import pkt_rule_pkg::*;
#(
    parameter int SLOTS = NUM_SLOTS
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  slot_idx_t             wr_slot,
    input  rule_t                 wr_rule,
    output rule_t [SLOTS-1:0]     rules
);

    // One register per slot; a write touches only the addressed slot.
    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                rules[s] <= '0;
            end else if (wr_en && (wr_slot == slot_idx_t'(s))) begin
                rules[s] <= wr_rule;
            end
        end
    end

    // R9: the addressed slot takes the written rule on the next cycle
    assert_write_lands_R9: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (rules[$past(wr_slot)] == $past(wr_rule)));

endmodule

// File: rtl/pkt_rule_match.sv
module pkt_rule_match
    import pkt_rule_pkg::*;
#(
    parameter int SLOTS = NUM_SLOTS
) (
    input  rule_t [SLOTS-1:0] rules,
    input  pkt_id_t           id,
    output lookup_t           result
);

    logic [SLOTS-1:0] slot_hit;
    logic [SLOTS-1:0] grant;

    // Per-slot compare and strict lowest-index priority.
    for (genvar s = 0; s < SLOTS; s++) begin : g_cmp
        assign slot_hit[s] = rule_accepts(rules[s], id);
        if (s == 0) begin : g_first
            assign grant[s] = slot_hit[s];
        end else begin : g_rest
            assign grant[s] = slot_hit[s] && !(|slot_hit[s-1:0]);
        end
    end

    // Encode the single granted slot; all-zero fields on a miss.
    always_comb begin
        result = '0;
        for (int s = 0; s < SLOTS; s++) begin
            if (grant[s]) begin
                result.hit  = 1'b1;
                result.slot = slot_idx_t'(s);
                result.tag  = result.tag | rules[s].tag;
            end
        end
    end

    // R4: at most one slot wins, and a win exists whenever any slot matches
    always_comb begin
        assert_single_winner_R4: assert ($onehot0(grant));
        assert_win_if_any_R4: assert ((|grant) == (|slot_hit));
    end

endmodule

// File: rtl/pkt_rule_matcher.sv
module pkt_rule_matcher
    import pkt_rule_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_we,
    input  logic [SLOT_W-1:0] cfg_slot,
    input  logic [ID_W-1:0]  cfg_mask,
    input  logic [ID_W-1:0]  cfg_value,
    input  logic [TAG_W-1:0] cfg_tag,
    input  logic             cfg_valid,
    input  logic             hdr_valid,
    output logic             hdr_ready,
    input  logic [HDR_W-1:0] hdr_data,
    output logic             res_valid,
    output logic             res_hit,
    output logic             res_miss,
    output logic [TAG_W-1:0] res_tag,
    output logic [SLOT_W-1:0] res_slot
);

    rule_t                  wr_rule;
    rule_t [NUM_SLOTS-1:0]  table_q;
    lookup_t                lookup_d;
    lookup_t                lookup_q;
    logic                   res_v_q;
    logic                   accept;

    assign wr_rule   = '{valid: cfg_valid, mask: cfg_mask, value: cfg_value, tag: cfg_tag};
    assign hdr_ready = !rst;
    assign accept    = hdr_valid && hdr_ready;

    pkt_rule_table #(.SLOTS(NUM_SLOTS)) u_table (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (cfg_we),
        .wr_slot (cfg_slot),
        .wr_rule (wr_rule),
        .rules   (table_q)
    );

    pkt_rule_match #(.SLOTS(NUM_SLOTS)) u_match (
        .rules  (table_q),
        .id     (header_to_id(hdr_data)),
        .result (lookup_d)
    );

    // Single result stage: the lookup sees the table before any same-cycle write.
    always_ff @(posedge clk) begin
        if (rst) begin
            res_v_q  <= 1'b0;
            lookup_q <= '0;
        end else begin
            res_v_q <= accept;
            if (accept) begin
                lookup_q <= lookup_d;
            end
        end
    end

    assign res_valid = res_v_q;
    assign res_hit   = res_v_q && lookup_q.hit;
    assign res_miss  = res_v_q && !lookup_q.hit;
    assign res_tag   = res_v_q ? lookup_q.tag  : '0;
    assign res_slot  = res_v_q ? lookup_q.slot : '0;

    // R6: one result per accepted header, exactly one cycle later
    assert_accept_gives_result_R6: assert property (@(posedge clk) disable iff (rst)
        accept |=> res_valid);
    assert_no_result_without_accept_R6: assert property (@(posedge clk) disable iff (rst)
        !accept |=> !res_valid);
    // R10: hit and miss are exclusive and only present with a result
    assert_hit_xor_miss_R10: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> (res_hit != res_miss));
    assert_flags_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        !res_valid |-> (!res_hit && !res_miss));
    // R7: a miss carries zero tag and slot
    assert_miss_fields_zero_R7: assert property (@(posedge clk) disable iff (rst)
        res_miss |-> (res_tag == '0 && res_slot == '0));

endmodule

// File: tb/pkt_rule_matcher_tb.sv
module pkt_rule_matcher_tb;

    localparam int CLK_PERIOD = 10;
    localparam int SLOTS = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_slot = '0;
    logic [4:0]  cfg_mask = '0;
    logic [4:0]  cfg_value = '0;
    logic [2:0]  cfg_tag = '0;
    logic        cfg_valid = 1'b0;
    logic        hdr_valid = 1'b0;
    logic        hdr_ready;
    logic [31:0] hdr_data = '0;
    logic        res_valid, res_hit, res_miss;
    logic [2:0]  res_tag;
    logic [1:0]  res_slot;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 0;

    // Bench copy of the rules it has written.
    bit       m_valid [SLOTS];
    bit [4:0] m_mask  [SLOTS];
    bit [4:0] m_value [SLOTS];
    bit [2:0] m_tag   [SLOTS];

    always #(CLK_PERIOD/2) clk = ~clk;

    pkt_rule_matcher u_dut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_slot(cfg_slot),
        .cfg_mask(cfg_mask), .cfg_value(cfg_value), .cfg_tag(cfg_tag),
        .cfg_valid(cfg_valid), .hdr_valid(hdr_valid), .hdr_ready(hdr_ready),
        .hdr_data(hdr_data), .res_valid(res_valid), .res_hit(res_hit),
        .res_miss(res_miss), .res_tag(res_tag), .res_slot(res_slot)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic model_clear();
        for (int s = 0; s < SLOTS; s++) begin
            m_valid[s] = 0; m_mask[s] = 0; m_value[s] = 0; m_tag[s] = 0;
        end
    endtask

    task automatic set_cfg(input int s, input int mk, input int vl, input int tg, input bit v);
        cfg_we = 1'b1; cfg_slot = 2'(s); cfg_mask = 5'(mk);
        cfg_value = 5'(vl); cfg_tag = 3'(tg); cfg_valid = v;
    endtask

    task automatic write_rule(input int s, input int mk, input int vl, input int tg, input bit v);
        @(negedge clk);
        set_cfg(s, mk, vl, tg, v);
        @(negedge clk);
        cfg_we = 1'b0;
        m_valid[s] = v; m_mask[s] = 5'(mk); m_value[s] = 5'(vl); m_tag[s] = 3'(tg);
    endtask

    // Expected lookup computed from the requirement text.
    task automatic expect_for(input int id, output bit hit, output int tag, output int slot);
        hit = 0; tag = 0; slot = 0;
        for (int s = SLOTS - 1; s >= 0; s--) begin
            if (m_valid[s] && ((5'(id) & m_mask[s]) == m_value[s])) begin
                hit = 1; tag = m_tag[s]; slot = s;
            end
        end
    endtask

    task automatic check_result(input int id, input string req);
        bit eh; int et; int es;
        expect_for(id, eh, et, es);
        check(res_valid == 1'b1, "R6", res_valid, 1);
        check(res_hit == eh && res_miss == !eh, req, res_hit, eh);
        check(res_tag == 3'(et), req, res_tag, et);
        check(res_slot == 2'(es), req, res_slot, es);
        if (!eh) check(res_tag == 0 && res_slot == 0, "R7", res_tag, 0);
    endtask

    task automatic lookup(input int id, input string req);
        @(negedge clk);
        hdr_valid = 1'b1;
        hdr_data = ((32'(id) * 32'h9E3779B1) & ~32'h1F) | 32'(id);
        @(negedge clk);
        hdr_valid = 1'b0;
        check_result(id, req);
    endtask

    task automatic sweep(input string req);
        for (int id = 0; id < 32; id++) lookup(id, req);
        @(negedge clk);
        check(res_valid == 1'b0 && !res_hit && !res_miss, "R6/R10 idle", res_valid, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        model_clear();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(res_valid == 1'b0, "R1 res_valid", res_valid, 0);
        check(hdr_ready == 1'b1, "R10 hdr_ready", hdr_ready, 1);
        sweep("R1 empty table");

        // Overlapping rules: narrow ones first; slot 3 invalid catch-all.
        write_rule(0, 31, 2, 1, 1);
        write_rule(1, 24, 0, 2, 1);
        write_rule(2, 30, 8, 3, 1);
        write_rule(3, 0, 0, 7, 0);
        sweep("R2/R4/R5/R8");
        lookup(2, "R4 narrow first");
        check(res_tag == 3'd1, "R4 ID2 tag", res_tag, 1);
        lookup(9, "R3 mask30");
        check(res_hit && res_tag == 3'd3, "R3 ID9", res_tag, 3);
        lookup(10, "R3 mask30 outside");
        check(res_miss, "R3 ID10 miss", res_miss, 1);

        // Stored value with bits outside mask never matches.
        write_rule(2, 24, 1, 4, 1);
        lookup(1, "R2 value outside mask");
        check(res_tag == 3'd2, "R2 ID1 via slot1", res_tag, 2);
        sweep("R2 unreachable value");

        // Valid catch-all in last slot.
        write_rule(3, 0, 0, 5, 1);
        sweep("R4 catch-all last");
        // Catch-all first: every ID lands in slot 0.
        write_rule(0, 0, 0, 6, 1);
        sweep("R4 catch-all first");
        // Invalidate slot 0 (R5), other slots untouched (R9).
        write_rule(0, 0, 0, 6, 0);
        sweep("R5/R9 slot0 invalid");

        // R9: header and write in the same cycle see the old table.
        @(negedge clk);
        set_cfg(0, 31, 13, 2, 1);
        hdr_valid = 1'b1;
        hdr_data = 32'hFFFF_FFED; // ID 13
        @(negedge clk);
        cfg_we = 1'b0;
        hdr_valid = 1'b0;
        check_result(13, "R9 old table");
        m_valid[0] = 1; m_mask[0] = 31; m_value[0] = 13; m_tag[0] = 2;
        lookup(13, "R9 new table");
        check(res_slot == 2'd0 && res_tag == 3'd2, "R9 slot0 wins", res_slot, 0);

        // R1: reset clears the table.
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        model_clear();
        check(res_valid == 1'b0, "R1 after reset", res_valid, 0);
        sweep("R1 cleared");

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule